// File: doc/BRIEF.md
# Return-Address Stack Controller over Shared Data RAM

This block manages a last-in, first-out store of subroutine return addresses that lives inside a general-purpose byte-wide data RAM. It holds only a small stack pointer of its own; the saved program counter values sit in RAM as byte pairs. The pairs start at a fixed base address, and the pointer selects which pair is used.

A call or interrupt pulses the push strobe with the current program counter. The block writes that value into the pair the pointer currently selects, using two RAM write cycles, and then advances the pointer. A return pulses the pop strobe. The block first steps the pointer back, then reads the selected pair in two RAM read cycles and presents the rebuilt program counter with a one-cycle valid pulse. The RAM port uses a combinational read: the data for an address is sampled in the same cycle the address is driven.

Top module: `retstack_top`

## Requirements
- R1: After reset the stack pointer is 0, busy is low, the RAM write enable is low and the PC-valid strobe is low.
- R2: A push writes PC bits [7:0] to address BASE + 2*SP (BASE = 8) in the first cycle after the request. In the second cycle it writes PC bits [10:8] to the next (odd) address, in data bits [2:0], with data bits [7:3] zero.
- R3: A push advances the stack pointer by one only after both bytes are written. The new value is visible in the cycle after the second write.
- R4: A pop lowers the stack pointer by one in the cycle after the request. It then reads the low byte from BASE + 2*SP and the high byte from the following address, each over one cycle. The RAM write enable stays low throughout.
- R5: In the cycle after the high-byte read, the PC-valid output is high for exactly one cycle, and the PC output holds {high byte bits [2:0], low byte}.
- R6: Busy is high for exactly two cycles per accepted push or pop. Push and pop requests seen while busy is high are ignored.
- R7: The pointer wraps modulo 8. A ninth push without a pop overwrites the pair at addresses 8 and 9. A pop from pointer 0 reads addresses 22 and 23 and leaves the pointer at 7.
- R8: When push and pop are requested in the same idle cycle, the push is carried out and the pop is dropped.
- R9: While busy, the RAM address always lies within 8 to 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushReq | input | 1 | Save pcIn on the stack (call or interrupt) |
| popReq | input | 1 | Restore the top entry (return) |
| pcIn | input | 11 | Program counter to save |
| pcOut | output | 11 | Restored program counter |
| pcValid | output | 1 | One-cycle strobe: pcOut holds a restored value |
| busy | output | 1 | Two-cycle RAM sequence in progress |
| stackPtr | output | 3 | Current stack pointer |
| ramAddr | output | 6 | RAM byte address |
| ramWrData | output | 8 | RAM write data |
| ramWe | output | 1 | RAM write enable |
| ramRdData | input | 8 | RAM read data for ramAddr, same cycle |

## Verification
The bench builds the block with its defaults: an 11-bit program counter split over 8-bit bytes, eight levels and base address 8. With eight levels, pointer wraparound in both directions takes only a handful of operations. The bench therefore drives a pop from an empty stack, a ninth push that overwrites the bottom pair, and long random push and pop mixes that cross the wrap point many times. It also reaches the high-byte packing of 11-bit values and checks that strobes arriving while busy, or at the same time as a push, have no effect.

// File: rtl/retstack_pkg.sv
package retstack_pkg;

  typedef struct packed {
    logic capturePc;
    logic spInc;
    logic spDec;
    logic selHi;
    logic writeEn;
    logic loadLo;
    logic loadHi;
    logic done;
  } stackStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PUSH_LO,
    ST_PUSH_HI,
    ST_POP_LO,
    ST_POP_HI
  } stackState_t;

endpackage

// File: rtl/retstack_ctrl.sv
module retstack_ctrl
  import retstack_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          pushReq,
  input  logic          popReq,
  output stackStrobes_t strobes,
  output logic          busy
);

  stackState_t stateQ, stateD;

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    unique case (stateQ)
      ST_IDLE: begin
        if (pushReq) begin
          strobes.capturePc = 1'b1;
          stateD            = ST_PUSH_LO;
        end else if (popReq) begin
          strobes.spDec = 1'b1;
          stateD        = ST_POP_LO;
        end
      end
      ST_PUSH_LO: begin
        strobes.writeEn = 1'b1;
        stateD          = ST_PUSH_HI;
      end
      ST_PUSH_HI: begin
        strobes.writeEn = 1'b1;
        strobes.selHi   = 1'b1;
        strobes.spInc   = 1'b1;
        stateD          = ST_IDLE;
      end
      ST_POP_LO: begin
        strobes.loadLo = 1'b1;
        stateD         = ST_POP_HI;
      end
      ST_POP_HI: begin
        strobes.selHi  = 1'b1;
        strobes.loadHi = 1'b1;
        strobes.done   = 1'b1;
        stateD         = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign busy = (stateQ != ST_IDLE);

endmodule

// File: rtl/retstack_dp.sv
module retstack_dp
  import retstack_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int LEVELS = 8,
  parameter int BASE   = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  stackStrobes_t               strobes,
  input  logic [PC_W-1:0]             pcIn,
  input  logic [DATA_W-1:0]           ramRdData,
  output logic [PC_W-1:0]             pcOut,
  output logic                        pcValid,
  output logic [$clog2(LEVELS)-1:0]   stackPtr,
  output logic [ADDR_W-1:0]           ramAddr,
  output logic [DATA_W-1:0]           ramWrData,
  output logic                        ramWe
);

  localparam int SP_W = $clog2(LEVELS);
  localparam int HI_W = PC_W - DATA_W;

  logic [SP_W-1:0]   spQ;
  logic [PC_W-1:0]   pcHoldQ;
  logic [PC_W-1:0]   pcOutQ;
  logic              validQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      spQ     <= '0;
      pcHoldQ <= '0;
      pcOutQ  <= '0;
      validQ  <= 1'b0;
    end else begin
      if (strobes.capturePc) pcHoldQ <= pcIn;
      if (strobes.spInc)     spQ <= spQ + 1'b1;
      else if (strobes.spDec) spQ <= spQ - 1'b1;
      if (strobes.loadLo)    pcOutQ[DATA_W-1:0] <= ramRdData;
      if (strobes.loadHi)    pcOutQ[PC_W-1:DATA_W] <= ramRdData[HI_W-1:0];
      validQ <= strobes.done;
    end
  end

  assign ramAddr   = ADDR_W'(BASE) + ADDR_W'({spQ, strobes.selHi});
  assign ramWrData = strobes.selHi ? DATA_W'(pcHoldQ[PC_W-1:DATA_W])
                                   : pcHoldQ[DATA_W-1:0];
  assign ramWe     = strobes.writeEn;
  assign stackPtr  = spQ;
  assign pcOut     = pcOutQ;
  assign pcValid   = validQ;

endmodule

// File: rtl/retstack_top.sv
module retstack_top
  import retstack_pkg::*;
#(
  parameter int PC_W   = 11,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int LEVELS = 8,
  parameter int BASE   = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       pushReq,
  input  logic                       popReq,
  input  logic [PC_W-1:0]            pcIn,
  output logic [PC_W-1:0]            pcOut,
  output logic                       pcValid,
  output logic                       busy,
  output logic [$clog2(LEVELS)-1:0]  stackPtr,
  output logic [ADDR_W-1:0]          ramAddr,
  output logic [DATA_W-1:0]          ramWrData,
  output logic                       ramWe,
  input  logic [DATA_W-1:0]          ramRdData
);

  stackStrobes_t strobes;

  retstack_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pushReq (pushReq),
    .popReq  (popReq),
    .strobes (strobes),
    .busy    (busy)
  );

  retstack_dp #(
    .PC_W   (PC_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .LEVELS (LEVELS),
    .BASE   (BASE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .pcIn      (pcIn),
    .ramRdData (ramRdData),
    .pcOut     (pcOut),
    .pcValid   (pcValid),
    .stackPtr  (stackPtr),
    .ramAddr   (ramAddr),
    .ramWrData (ramWrData),
    .ramWe     (ramWe)
  );

endmodule

// File: rtl/retstack_chk.sv
module retstack_chk #(
  parameter int PC_W   = 11,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int LEVELS = 8,
  parameter int BASE   = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       pushReq,
  input logic                       popReq,
  input logic [PC_W-1:0]            pcIn,
  input logic [PC_W-1:0]            pcOut,
  input logic                       pcValid,
  input logic                       busy,
  input logic [$clog2(LEVELS)-1:0]  stackPtr,
  input logic [ADDR_W-1:0]          ramAddr,
  input logic [DATA_W-1:0]          ramWrData,
  input logic                       ramWe,
  input logic [DATA_W-1:0]          ramRdData
);

  localparam int SP_W = $clog2(LEVELS);
  localparam int TOP  = BASE + 2 * LEVELS - 1;

  // R1: state right after reset is released
  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rstN) |-> (stackPtr == '0 && !busy && !ramWe && !pcValid));

  // R2: first push cycle writes the even address of the current pair
  assert_push_lo_addr_R2: assert property (@(posedge clk) disable iff (!rstN)
    (pushReq && !busy) |=> (ramWe && ramAddr == ADDR_W'(BASE + 2 * int'($past(stackPtr)))));

  // R2: high byte carries no bits above the program counter width
  assert_hi_byte_pad_R2: assert property (@(posedge clk) disable iff (!rstN)
    (ramWe && ramAddr[0]) |-> ((ramWrData >> (PC_W - DATA_W)) == '0));

  // R3: pointer advances once the write pair completes
  assert_push_post_inc_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(ramWe) && !ramWe) |-> (stackPtr == SP_W'($past(stackPtr) + 1'b1)));

  // R4: pop lowers the pointer before reading
  assert_pop_pre_dec_R4: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !pushReq && !busy) |=> (stackPtr == SP_W'($past(stackPtr) - 1'b1) && !ramWe));

  // R5: valid strobe lasts one cycle
  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    pcValid |=> !pcValid);

  // R6: each sequence occupies exactly two busy cycles
  assert_busy_len_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> (busy ##1 !busy));

  // R9: addresses stay inside the stack region
  assert_addr_window_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (int'(ramAddr) >= BASE && int'(ramAddr) <= TOP));

endmodule

bind retstack_top retstack_chk #(
  .PC_W   (PC_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .LEVELS (LEVELS),
  .BASE   (BASE)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .pushReq   (pushReq),
  .popReq    (popReq),
  .pcIn      (pcIn),
  .pcOut     (pcOut),
  .pcValid   (pcValid),
  .busy      (busy),
  .stackPtr  (stackPtr),
  .ramAddr   (ramAddr),
  .ramWrData (ramWrData),
  .ramWe     (ramWe),
  .ramRdData (ramRdData)
);

// File: tb/retstack_top_tb.sv
`timescale 1ns/1ps
module retstack_top_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pushReq = 1'b0;
  logic        popReq = 1'b0;
  logic [10:0] pcIn = '0;
  logic [10:0] pcOut;
  logic        pcValid;
  logic        busy;
  logic [2:0]  stackPtr;
  logic [5:0]  ramAddr;
  logic [7:0]  ramWrData;
  logic        ramWe;
  logic [7:0]  ramRdData;

  logic [7:0]  mem [64];
  logic [10:0] modelStack [8];
  logic [2:0]  msp;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  retstack_top u_dut (
    .clk(clk), .rstN(rstN), .pushReq(pushReq), .popReq(popReq), .pcIn(pcIn),
    .pcOut(pcOut), .pcValid(pcValid), .busy(busy), .stackPtr(stackPtr),
    .ramAddr(ramAddr), .ramWrData(ramWrData), .ramWe(ramWe), .ramRdData(ramRdData)
  );

  assign ramRdData = mem[ramAddr];
  always @(posedge clk) if (ramWe) mem[ramAddr] <= ramWrData;

  function automatic logic [5:0] pairAddr(input logic [2:0] sp, input bit hi);
    return 6'(8 + 2 * int'(sp) + (hi ? 1 : 0));
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // mode 0: plain, 1: pop asserted together with push, 2: pop asserted while busy
  task automatic doPush(input logic [10:0] pc, input int mode);
    @(negedge clk);
    pushReq = 1'b1; pcIn = pc;
    if (mode == 1) popReq = 1'b1;
    @(negedge clk);
    pushReq = 1'b0;
    popReq  = (mode == 2);
    check(busy && ramWe, "R6 busy/we lo", {busy, ramWe}, 3);
    check(ramAddr == pairAddr(msp, 0), "R2 lo addr", ramAddr, pairAddr(msp, 0));
    check(ramWrData == pc[7:0], "R2 lo data", ramWrData, pc[7:0]);
    check(stackPtr == msp, "R3 no early inc", stackPtr, msp);
    @(negedge clk);
    check(ramWe && ramAddr == pairAddr(msp, 1), "R2 hi addr", ramAddr, pairAddr(msp, 1));
    check(ramWrData == {5'b0, pc[10:8]}, "R2 hi data", ramWrData, {5'b0, pc[10:8]});
    @(negedge clk);
    popReq = 1'b0;
    modelStack[msp] = pc;
    check(mem[pairAddr(msp, 0)] == pc[7:0] && mem[pairAddr(msp, 1)] == {5'b0, pc[10:8]},
          "R2 ram contents", {mem[pairAddr(msp, 1)], mem[pairAddr(msp, 0)]}, pc);
    msp = msp + 3'd1;
    check(!busy, "R6 busy end", busy, 0);
    check(stackPtr == msp, (mode == 0) ? "R3 post inc" : "R8/R6 pop ignored", stackPtr, msp);
  endtask

  task automatic doPop();
    logic [10:0] exp;
    @(negedge clk);
    popReq = 1'b1;
    @(negedge clk);
    popReq = 1'b0;
    msp = msp - 3'd1;
    exp = modelStack[msp];
    check(stackPtr == msp && busy, "R4 pre dec", stackPtr, msp);
    check(!ramWe && ramAddr == pairAddr(msp, 0), "R4 lo read", ramAddr, pairAddr(msp, 0));
    @(negedge clk);
    check(!ramWe && ramAddr == pairAddr(msp, 1), "R4 hi read", ramAddr, pairAddr(msp, 1));
    @(negedge clk);
    check(pcValid && !busy, "R5 valid", pcValid, 1);
    check(pcOut == exp, "R5 pc value", pcOut, exp);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) modelStack[i] = '0;
    msp = '0;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    check(stackPtr == 0 && !busy && !ramWe && !pcValid, "R1 reset", {stackPtr, busy, ramWe, pcValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(stackPtr == 0 && !busy, "R1 after release", stackPtr, 0);
    // R7: pop from empty wraps to 7 and reads addresses 22/23
    doPop();
    check(stackPtr == 3'd7, "R7 pop wrap", stackPtr, 7);
    doPush(11'h000, 0);
    check(stackPtr == 3'd0, "R7 push wrap", stackPtr, 0);
    // fill all levels with distinct values, then overwrite level 0 (R7)
    for (int i = 0; i < 8; i++) doPush(11'(11'h7F0 ^ (i * 11'h111)), 0);
    doPush(11'h5A5, 0);
    check(mem[8] == 8'hA5 && mem[9] == 8'h05, "R7 ninth push overwrite", {mem[9], mem[8]}, 12'h5A5);
    doPush(11'h7FF, 1);   // R8
    doPush(11'h123, 2);   // R6
    doPop();
    @(negedge clk);
    check(!pcValid, "R5 single pulse", pcValid, 0);
    doPop();
    for (int n = 0; n < 200; n++) begin
      if ($urandom_range(1, 0) == 1) doPush(11'($urandom), int'($urandom_range(2, 0)));
      else doPop();
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule